// File: doc/BRIEF.md
# Masked Component Register File With Decoder Commit

This block is a 256-byte, 32-bit register region for the cache and memory side of a component's capability space. A host reaches it through a simple valid/ready request port carrying a byte address, a size code and write data. Read data comes back one cycle after a read is accepted. Each register has its own per-bit write mask. On a write, the masked bits take the new data and every other bit keeps its stored value, so read-only fields can never be changed.

At reset the block samples a 3-bit component profile and builds the capability header list from it. The profile sets how many capability blocks are announced: error reporting and link always, the address decoder block for some profiles, and two further headers for the richest one. The block holds the error mask and severity registers with their reset values. It also holds the decoder capability, the decoder global control register and one register set per decoder. A write that sets a decoder's commit bit completes at once: commit reads back 0, error reads back 0 and committed reads back 1.

The `NUM_DEC` parameter sets the number of decoder sets. It may be 1 or 2 so that the decoder sets stay below the offset 0xE0.

Top module: `crf_regfile`

## Requirements
- R1: Only the 4-byte size code (2) is honoured. With size codes 0, 1 or 3 (1, 2 or 8 bytes), a read returns 0, a write changes nothing, and no error is flagged.
- R2: A write stores (wdata AND mask) OR (old AND NOT mask). Bits outside a register's mask never change.
- R3: The word at 0x00 holds id 1 in [15:0], version 1 in [19:16], cache-mem version 1 in [23:20] and the capability count in [31:24]. The count comes from the profile code: codes 0 and 1 give 2; codes 2, 3 and 4 give 3; code 5 gives 5; codes 6 and 7 give 2.
- R4: Slot k (k = 1..5) sits at 0x00+4k. It holds id in [15:0], version in [19:16] and the block's byte offset in [31:20]. The slots, in order, are: error reporting (id 2, ver 2, 0x040), link (id 4, ver 2, 0x060), decoder (id 5, ver 1, 0x080), extended security (id 6, ver 1, 0x0E0) and snoop (id 8, ver 1, 0x0F0). A slot whose number is above the count reads 0.
- R5: The profile is captured only while rst_n is low. Later changes to prof_i have no effect.
- R6: The error block holds five registers:
  - uncorrectable status at 0x40: reads 0, read-only.
  - uncorrectable mask at 0x44: reset 0x1CFFF, mask 0x1CFFF.
  - uncorrectable severity at 0x48: reset 0x1CFFF, mask 0x1CFFF.
  - correctable status at 0x4C: reads 0, read-only.
  - correctable mask at 0x50: reset 0x7F, mask 0x7F.
- R7: The decoder capability at 0x80 reads 0x310:
  - [3:0] is the log2 of the decoder count.
  - [7:4] is the target count, 1.
  - bit 8 reports 256-byte interleave support, 1.
  - bit 9 reports 4 KB interleave support, 1.
  - bit 10 reports poison-on-error support, 0.

  Global control at 0x84 resets to 0 with mask 0x3. When the count is below 3, all decoder-block offsets read 0 and ignore writes.
- R8: Decoder d starts at 0x90+0x20·d. Its registers are:
  - base-low at +0x0, mask 0xF0000000.
  - base-high at +0x4, mask 0xFFFFFFFF.
  - size-low at +0x8, mask 0xF0000000.
  - size-high at +0xC, mask 0xFFFFFFFF.
  - control at +0x10, mask 0x13FF.

  All of them reset to 0.
- R9: When a write to decoder control carries commit (bit 9) as 1, the stored word has bit 9 = 0, error (bit 11) = 0 and committed (bit 10) = 1. Committed then stays 1.
- R10: Offsets with no register read 0 and ignore writes.
- R11: A request with addr[1:0] ≠ 0 sets rsp_err in its response, returns 0 and changes nothing.
- R12: req_ready is 0 in reset and 1 from the first edge after it. rsp_valid is high exactly in the cycle after each accepted request, with rsp_rdata and rsp_err valid at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prof_i | input | 3 | Component profile code, sampled during reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the region |
| req_size | input | 2 | Size code: 0=1 B, 1=2 B, 2=4 B, 3=8 B |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the request accepted one cycle earlier |
| rsp_rdata | output | 32 | Read data (0 for writes and refused reads) |
| rsp_err | output | 1 | Misaligned request flag |

## Verification
The checks assume that req_valid, req_write, req_addr and req_size are held steady and defined while a request is being accepted. They also assume that prof_i is settled before rst_n rises. The bench drives every request on the falling edge, holds it for one full cycle and drops req_valid afterwards. It changes the profile only inside reset, except in the one scenario that deliberately changes it afterwards to show that the change is ignored. All offsets and size codes it uses fit the 8-bit address and 2-bit size fields, so no property sees an undefined input.

// File: rtl/crf_pkg.sv
package crf_pkg;

  typedef logic [31:0] word_t;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  localparam int MAX_SLOTS = 5;
  localparam int DEC_NREG  = 5;

  // block offsets announced in the header slots
  localparam logic [11:0] BLK_ERR  = 12'h040;
  localparam logic [11:0] BLK_LINK = 12'h060;
  localparam logic [11:0] BLK_DEC  = 12'h080;
  localparam logic [11:0] BLK_XSEC = 12'h0E0;
  localparam logic [11:0] BLK_SNP  = 12'h0F0;

  // register byte offsets
  localparam int OFF_UNC_MSK = 'h44;
  localparam int OFF_UNC_SEV = 'h48;
  localparam int OFF_COR_MSK = 'h50;
  localparam int OFF_DCAP    = 'h80;
  localparam int OFF_GCTL    = 'h84;
  localparam int OFF_DEC0    = 'h90;
  localparam int DEC_STRIDE  = 'h20;

  // per-register write masks
  localparam word_t WM_UNC  = 32'h0001_CFFF;
  localparam word_t WM_COR  = 32'h0000_007F;
  localparam word_t WM_GCTL = 32'h0000_0003;
  localparam word_t WM_LO   = 32'hF000_0000;
  localparam word_t WM_HI   = 32'hFFFF_FFFF;
  localparam word_t WM_DCTL = 32'h0000_13FF;

  localparam int CTL_COMMIT = 9;
  localparam int CTL_DONE   = 10;
  localparam int CTL_ERR    = 11;

  function automatic word_t merge_w(word_t wd, word_t cur, word_t msk);
    return (wd & msk) | (cur & ~msk);
  endfunction

  function automatic logic [7:0] prof_count(logic [2:0] p);
    case (p)
      3'd2, 3'd3, 3'd4: return 8'd3;
      3'd5:             return 8'd5;
      default:          return 8'd2;
    endcase
  endfunction

  function automatic word_t top_hdr(logic [7:0] n);
    return {n, 4'd1, 4'd1, 16'd1};
  endfunction

  function automatic word_t slot_hdr(int k);
    case (k)
      1:       return {BLK_ERR,  4'd2, 16'd2};
      2:       return {BLK_LINK, 4'd2, 16'd4};
      3:       return {BLK_DEC,  4'd1, 16'd5};
      4:       return {BLK_XSEC, 4'd1, 16'd6};
      5:       return {BLK_SNP,  4'd1, 16'd8};
      default: return '0;
    endcase
  endfunction

  function automatic word_t dec_cap(int ndec);
    logic [3:0] enc;
    enc = 4'($clog2(ndec));
    return {21'd0, 1'b0, 1'b1, 1'b1, 4'd1, enc};
  endfunction

  function automatic word_t commit_fix(word_t w);
    word_t r;
    r = w;
    if (w[CTL_COMMIT]) begin
      r[CTL_COMMIT] = 1'b0;
      r[CTL_ERR]    = 1'b0;
      r[CTL_DONE]   = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/crf_masked_reg.sv
module crf_masked_reg
  import crf_pkg::*;
#(
  parameter word_t RST  = '0,
  parameter word_t MASK = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  word_t wdata,
  output word_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST;
    else if (we) q <= merge_w(wdata, q, MASK);
  end

  AST_RO_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (((q ^ $past(q)) & ~MASK) == '0)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R10

endmodule

// File: rtl/crf_hdm_decoder.sv
module crf_hdm_decoder
  import crf_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DEC_NREG-1:0]          we_i,
  input  word_t                        wdata_i,
  output logic [DEC_NREG-1:0][31:0]    regs_o
);

  localparam int CTL_IDX = DEC_NREG - 1;

  // base/size halves: even index = low half, odd index = high half
  for (genvar i = 0; i < CTL_IDX; i++) begin : g_addr
    localparam word_t M = (i % 2 == 0) ? WM_LO : WM_HI;
    crf_masked_reg #(.RST('0), .MASK(M)) u_r (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we_i[i]),
      .wdata (wdata_i),
      .q     (regs_o[i])
    );
  end

  word_t ctl_q;
  logic  commit_wr;

  assign commit_wr = we_i[CTL_IDX] & wdata_i[CTL_COMMIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ctl_q <= '0;
    else if (we_i[CTL_IDX])   ctl_q <= commit_fix(merge_w(wdata_i, ctl_q, WM_DCTL));
  end

  assign regs_o[CTL_IDX] = ctl_q;

  AST_COMMIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_wr |=> (ctl_q[CTL_DONE] && !ctl_q[CTL_COMMIT] && !ctl_q[CTL_ERR])); // R9

  AST_COMMITTED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[CTL_DONE] |=> ctl_q[CTL_DONE]); // R9

endmodule

// File: rtl/crf_cap_hdr.sv
module crf_cap_hdr
  import crf_pkg::*;
(
  input  logic [7:0]                 cap_count,
  output logic [MAX_SLOTS:0][31:0]   hdr_o
);

  assign hdr_o[0] = top_hdr(cap_count);

  for (genvar k = 1; k <= MAX_SLOTS; k++) begin : g_slot
    assign hdr_o[k] = (cap_count >= 8'(k)) ? slot_hdr(k) : '0;
  end

endmodule

// File: rtl/crf_regfile.sv
module crf_regfile
  import crf_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_DEC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        prof_i,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err
);

  localparam word_t DCAP_W = dec_cap(NUM_DEC);

  // profile capture, only while in reset
  logic [2:0] prof_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prof_q <= prof_i;
  end

  logic [7:0] cap_count;
  logic       has_dec;
  assign cap_count = prof_count(prof_q);
  assign has_dec   = cap_count >= 8'd3;

  logic [MAX_SLOTS:0][31:0] hdr;
  crf_cap_hdr u_hdr (.cap_count(cap_count), .hdr_o(hdr));

  // request qualification
  logic accept, aligned, full_word, act, wr;
  int unsigned off;
  assign accept    = req_valid & req_ready;
  assign aligned   = req_addr[1:0] == 2'b00;
  assign full_word = req_size == SZ_WORD;
  assign act       = accept & aligned & full_word;
  assign wr        = act & req_write;
  assign off       = 32'(req_addr);

  // storage
  word_t unc_msk_q, unc_sev_q, cor_msk_q, gctl_q;
  logic  unc_msk_we, unc_sev_we, cor_msk_we, gctl_we;
  logic [NUM_DEC-1:0][DEC_NREG-1:0][31:0] dec_regs;
  logic [NUM_DEC-1:0][DEC_NREG-1:0]       dec_we;

  crf_masked_reg #(.RST(WM_UNC), .MASK(WM_UNC)) u_unc_msk (
    .clk(clk), .rst_n(rst_n), .we(unc_msk_we), .wdata(req_wdata), .q(unc_msk_q));
  crf_masked_reg #(.RST(WM_UNC), .MASK(WM_UNC)) u_unc_sev (
    .clk(clk), .rst_n(rst_n), .we(unc_sev_we), .wdata(req_wdata), .q(unc_sev_q));
  crf_masked_reg #(.RST(WM_COR), .MASK(WM_COR)) u_cor_msk (
    .clk(clk), .rst_n(rst_n), .we(cor_msk_we), .wdata(req_wdata), .q(cor_msk_q));
  crf_masked_reg #(.RST('0), .MASK(WM_GCTL)) u_gctl (
    .clk(clk), .rst_n(rst_n), .we(gctl_we), .wdata(req_wdata), .q(gctl_q));

  for (genvar d = 0; d < NUM_DEC; d++) begin : g_dec
    crf_hdm_decoder u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (dec_we[d]),
      .wdata_i (req_wdata),
      .regs_o  (dec_regs[d])
    );
  end

  // address decode
  word_t rd_word;
  always_comb begin
    rd_word    = '0;
    unc_msk_we = 1'b0;
    unc_sev_we = 1'b0;
    cor_msk_we = 1'b0;
    gctl_we    = 1'b0;
    dec_we     = '0;
    for (int k = 0; k <= MAX_SLOTS; k++) begin
      if (off == 32'(4 * k)) rd_word = hdr[k];
    end
    if (off == 32'(OFF_UNC_MSK)) begin rd_word = unc_msk_q; unc_msk_we = wr; end
    if (off == 32'(OFF_UNC_SEV)) begin rd_word = unc_sev_q; unc_sev_we = wr; end
    if (off == 32'(OFF_COR_MSK)) begin rd_word = cor_msk_q; cor_msk_we = wr; end
    if (has_dec) begin
      if (off == 32'(OFF_DCAP)) rd_word = DCAP_W;
      if (off == 32'(OFF_GCTL)) begin rd_word = gctl_q; gctl_we = wr; end
      for (int d = 0; d < NUM_DEC; d++) begin
        for (int r = 0; r < DEC_NREG; r++) begin
          if (off == 32'(OFF_DEC0 + d * DEC_STRIDE + r * 4)) begin
            rd_word      = dec_regs[d][r];
            dec_we[d][r] = wr;
          end
        end
      end
    end
  end

  // response stage
  logic ready_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      ready_q   <= 1'b1;
      rsp_valid <= accept;
      rsp_rdata <= (act && !req_write) ? rd_word : '0;
      rsp_err   <= accept & ~aligned;
    end
  end
  assign req_ready = ready_q;

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R12

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid); // R12

  AST_PARTIAL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && req_size != SZ_WORD) |=> (rsp_rdata == '0)); // R1

  AST_MISALIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[1:0] != 2'b00) |=> (rsp_err && rsp_rdata == '0)); // R11

  AST_PROFILE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(prof_q)); // R5

endmodule

// File: tb/test_crf_regfile.sv
module test_crf_regfile;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  prof_i = 3'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  crf_regfile #(.ADDR_W(8), .NUM_DEC(1)) i_crf_regfile (
    .clk(clk), .rst_n(rst_n), .prof_i(prof_i),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  function automatic logic [7:0] exp_count(input logic [2:0] p);
    if (p == 3'd5) return 8'd5;
    if (p >= 3'd2 && p <= 3'd4) return 8'd3;
    return 8'd2;
  endfunction

  function automatic logic [31:0] exp_slot(input int k);
    logic [11:0] ptr; logic [3:0] ver; logic [15:0] id;
    case (k)
      1: begin id = 16'd2; ver = 4'd2; ptr = 12'h040; end
      2: begin id = 16'd4; ver = 4'd2; ptr = 12'h060; end
      3: begin id = 16'd5; ver = 4'd1; ptr = 12'h080; end
      4: begin id = 16'd6; ver = 4'd1; ptr = 12'h0E0; end
      default: begin id = 16'd8; ver = 4'd1; ptr = 12'h0F0; end
    endcase
    return (32'(ptr) << 20) | (32'(ver) << 16) | 32'(id);
  endfunction

  task automatic do_reset(input logic [2:0] p);
    @(negedge clk);
    rst_n = 1'b0; prof_i = p; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 ready low in reset", 32'(req_ready), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 ready after reset", 32'(req_ready), 32'd1);
  endtask

  task automatic xact(input logic w, input logic [7:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd,
                      output logic er, output logic vl);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz; req_wdata = wd;
    @(negedge clk);
    rd = rsp_rdata; er = rsp_err; vl = rsp_valid;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd32(input logic [7:0] a, output logic [31:0] d);
    logic e, v;
    xact(1'b0, a, 2'd2, 32'd0, d, e, v);
  endtask

  task automatic wr32(input logic [7:0] a, input logic [31:0] wd);
    logic [31:0] d; logic e, v;
    xact(1'b1, a, 2'd2, wd, d, e, v);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset(3'd3);
    chk("R12 no response idle", 32'(rsp_valid), 32'd0);
    rd32(8'h44, d); chk("R6 unc mask reset", d, 32'h0001CFFF);
    rd32(8'h48, d); chk("R6 unc severity reset", d, 32'h0001CFFF);
    rd32(8'h50, d); chk("R6 cor mask reset", d, 32'h0000007F);
    rd32(8'h40, d); chk("R6 unc status reset", d, 32'h0);
    rd32(8'h4C, d); chk("R6 cor status reset", d, 32'h0);
    rd32(8'h80, d); chk("R7 decoder capability", d, 32'h00000310);
    rd32(8'h84, d); chk("R7 global control reset", d, 32'h0);
    rd32(8'hA0, d); chk("R8 decoder control reset", d, 32'h0);
  endtask

  task automatic t_headers(input logic [2:0] p);
    logic [31:0] d;
    logic [7:0] n;
    do_reset(p);
    n = exp_count(p);
    rd32(8'h00, d);
    chk("R3 top header", d, {n, 4'd1, 4'd1, 16'd1});
    for (int k = 1; k <= 5; k++) begin
      rd32(8'(4 * k), d);
      chk("R4 slot header", d, (k <= int'(n)) ? exp_slot(k) : 32'h0);
    end
  endtask

  task automatic t_profile_frozen();
    logic [31:0] d;
    do_reset(3'd0);
    prof_i = 3'd5;
    repeat (2) @(negedge clk);
    rd32(8'h00, d); chk("R5 count unchanged", d, 32'h02110001);
    rd32(8'h0C, d); chk("R5 slot 3 still empty", d, 32'h0);
  endtask

  task automatic t_merge();
    logic [31:0] d;
    do_reset(3'd3);
    wr32(8'h44, 32'hFFFFFFFF); rd32(8'h44, d); chk("R2 set all masked", d, 32'h0001CFFF);
    wr32(8'h44, 32'h00000000); rd32(8'h44, d); chk("R2 clear all masked", d, 32'h0);
    wr32(8'h48, 32'h0000A5A5); rd32(8'h48, d); chk("R2 severity pattern", d, 32'h0000A5A5 & 32'h1CFFF);
    wr32(8'h50, 32'hFFFFFF55); rd32(8'h50, d); chk("R2 cor mask pattern", d, 32'h55);
    wr32(8'h40, 32'hFFFFFFFF); rd32(8'h40, d); chk("R6 status read-only", d, 32'h0);
    wr32(8'h80, 32'h0);        rd32(8'h80, d); chk("R2 capability read-only", d, 32'h310);
  endtask

  task automatic t_decoder();
    logic [31:0] d;
    do_reset(3'd4);
    wr32(8'h90, 32'h12345678); rd32(8'h90, d); chk("R8 base low", d, 32'h10000000);
    wr32(8'h94, 32'hDEADBEEF); rd32(8'h94, d); chk("R8 base high", d, 32'hDEADBEEF);
    wr32(8'h98, 32'hFFFFFFFF); rd32(8'h98, d); chk("R8 size low", d, 32'hF0000000);
    wr32(8'h9C, 32'h0BADF00D); rd32(8'h9C, d); chk("R8 size high", d, 32'h0BADF00D);
    wr32(8'h84, 32'h000000FF); rd32(8'h84, d); chk("R7 global control mask", d, 32'h3);
    rd32(8'h90, d); chk("R8 base low kept", d, 32'h10000000);
  endtask

  task automatic t_commit();
    logic [31:0] d;
    do_reset(3'd3);
    wr32(8'hA0, 32'h00000005); rd32(8'hA0, d); chk("R8 control no commit", d, 32'h5);
    wr32(8'hA0, 32'hFFFFFFFF); rd32(8'hA0, d); chk("R9 commit completes", d, 32'h000015FF);
    wr32(8'hA0, 32'h00000000); rd32(8'hA0, d); chk("R9 committed sticky", d, 32'h00000400);
    wr32(8'hA0, 32'h00000200); rd32(8'hA0, d); chk("R9 recommit", d, 32'h00000400);
  endtask

  task automatic t_dec_gate();
    logic [31:0] d;
    do_reset(3'd1);
    rd32(8'h80, d); chk("R7 capability hidden", d, 32'h0);
    wr32(8'h84, 32'h3); rd32(8'h84, d); chk("R7 global control hidden", d, 32'h0);
    wr32(8'h90, 32'hFFFFFFFF); rd32(8'h90, d); chk("R7 decoder hidden", d, 32'h0);
    do_reset(3'd3);
    rd32(8'h84, d); chk("R7 no write leaked", d, 32'h0);
    rd32(8'h90, d); chk("R7 no decoder leak", d, 32'h0);
  endtask

  task automatic t_size();
    logic [31:0] d; logic e, v;
    do_reset(3'd3);
    xact(1'b0, 8'h44, 2'd3, 32'h0, d, e, v);
    chk("R1 8-byte read zero", d, 32'h0);
    chk("R1 8-byte no error", 32'(e), 32'd0);
    xact(1'b1, 8'h44, 2'd3, 32'h0, d, e, v);
    rd32(8'h44, d); chk("R1 8-byte write ignored", d, 32'h0001CFFF);
    xact(1'b0, 8'h50, 2'd1, 32'h0, d, e, v);
    chk("R1 2-byte read zero", d, 32'h0);
    xact(1'b1, 8'h50, 2'd0, 32'h0, d, e, v);
    rd32(8'h50, d); chk("R1 1-byte write ignored", d, 32'h7F);
  endtask

  task automatic t_misalign();
    logic [31:0] d; logic e, v;
    do_reset(3'd3);
    xact(1'b1, 8'h46, 2'd2, 32'h0, d, e, v);
    chk("R11 write error flag", 32'(e), 32'd1);
    rd32(8'h44, d); chk("R11 no state change", d, 32'h0001CFFF);
    xact(1'b0, 8'h41, 2'd2, 32'h0, d, e, v);
    chk("R11 read error flag", 32'(e), 32'd1);
    chk("R11 read data zero", d, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    do_reset(3'd5);
    wr32(8'hB4, 32'hFFFFFFFF); rd32(8'hB4, d); chk("R10 gap reads zero", d, 32'h0);
    rd32(8'h60, d); chk("R10 link block empty", d, 32'h0);
    wr32(8'hFC, 32'h12345678); rd32(8'hFC, d); chk("R10 top word empty", d, 32'h0);
  endtask

  task automatic t_timing();
    logic [31:0] d; logic e, v;
    do_reset(3'd3);
    xact(1'b0, 8'h50, 2'd2, 32'h0, d, e, v);
    chk("R12 response valid", 32'(v), 32'd1);
    chk("R12 data with response", d, 32'h7F);
    @(negedge clk);
    chk("R12 single-cycle response", 32'(rsp_valid), 32'd0);
    xact(1'b1, 8'h50, 2'd2, 32'h1, d, e, v);
    chk("R12 write response", 32'(v), 32'd1);
    chk("R12 write response data", d, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    t_reset_state();
    for (int p = 0; p < 8; p++) t_headers(3'(p));
    t_profile_frozen();
    t_merge();
    t_decoder();
    t_commit();
    t_dec_gate();
    t_size();
    t_misalign();
    t_unmapped();
    t_timing();
    summary();
    $finish;
  end

endmodule